// File: doc/BRIEF.md
# Handshaked Two-Sample Averaging Filter

A streaming filter that, for every sample it accepts, emits the mean of that sample and the sample accepted just before it. The earlier sample then gives way to the new one. Input and output are each a four-phase request/acknowledge channel. On such a channel a request that is raised marks the data as valid, and both wires fall back to zero before the next transfer.

The block is a clocked model of a self-timed stage. A control sequencer captures the incoming word into the current-sample register and acknowledges the sender. Once the sender withdraws its request, the sequencer waits a configurable matched delay that stands in for a bundled-data adder. It then loads the halved sum into the output holding register, moves the current sample into the previous-sample register and raises the output request. Only one result is ever in flight. A new sample is not acknowledged until the downstream side has taken the last result and released its acknowledge.

Top module: `avg2_filter`

## Requirements
- R1: After reset, in_ack_o and out_req_o are low, out_data_o is 0 and the previous sample is 0.
- R2: The first result after reset is the first input halved, because the previous sample starts at zero (input 10 gives 5).
- R3: Each result is floor((x + y) / 2), formed from a DATA_W+1-bit sum so that it cannot overflow (255 and 255 give 255 for DATA_W = 8).
- R4: After each transfer the previous sample takes the value of the sample just accepted.
- R5: in_ack_o rises only while in_req_i is high and the output channel is idle. It stays high while in_req_i is high and falls in the cycle after in_req_i is seen low.
- R6: in_data_i is sampled at the edge where in_ack_o rises. Later changes to in_data_i have no effect on the result.
- R7: out_req_o rises exactly ADD_LAT cycles after in_ack_o falls and stays low for that time.
- R8: While out_ack_i is low, out_req_o and out_data_o hold their values. out_req_o falls in the cycle after out_ack_i is seen high.
- R9: No new input is acknowledged while out_ack_i is still high from the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_req_i | input | 1 | Input request, data valid |
| in_data_i | input | DATA_W | Input sample, unsigned |
| in_ack_o | output | 1 | Input acknowledge |
| out_req_o | output | 1 | Output request, result valid |
| out_data_o | output | DATA_W | Averaged result |
| out_ack_i | input | 1 | Output acknowledge |

## Verification
A table of eight samples is fed in sequence. It covers a small first value, to expose a previous sample that is not zero at start, and a rising pair. It also has two all-ones words, which overflow a sum only DATA_W bits wide. A drop to zero follows, and then odd sums, which tell truncation apart from rounding. During each transfer the input word is overwritten as soon as it is acknowledged, to show that capture takes place at the acknowledge edge. The gap from input release to output request is counted on every transfer. Directed tests then keep the output acknowledge high to delay the next sample, and apply a reset mid-stream to show that the previous sample is cleared.

// File: rtl/avg2_pkg.sv
package avg2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_ADD  = 2'd2,
    ST_OUT  = 2'd3
  } avg2_state_e;
endpackage

// File: rtl/avg2_match_delay.sv
module avg2_match_delay #(
  parameter int ADD_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (ADD_LAT > 1) ? $clog2(ADD_LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(ADD_LAT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= '0;
    else if (run_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/avg2_ctrl.sv
module avg2_ctrl
  import avg2_pkg::*;
#(
  parameter int ADD_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_req_i,
  input  logic out_ack_i,
  output logic in_ack_o,
  output logic out_req_o,
  output logic cap_x_o,
  output logic commit_o
);
  avg2_state_e state_q, state_d;
  logic add_start, add_done;

  // matched delay of the bundled adder
  avg2_match_delay #(.ADD_LAT(ADD_LAT)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(add_start),
    .run_i  (state_q == ST_ADD),
    .done_o (add_done)
  );

  always_comb begin
    state_d   = state_q;
    cap_x_o   = 1'b0;
    commit_o  = 1'b0;
    add_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_req_i && !out_ack_i) begin
        cap_x_o = 1'b1;
        state_d = ST_HOLD;
      end
      ST_HOLD: if (!in_req_i) begin
        add_start = 1'b1;
        state_d   = ST_ADD;
      end
      ST_ADD: if (add_done) begin
        commit_o = 1'b1;
        state_d  = ST_OUT;
      end
      ST_OUT: if (out_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign in_ack_o  = (state_q == ST_HOLD);
  assign out_req_o = (state_q == ST_OUT);
endmodule

// File: rtl/avg2_datapath.sv
module avg2_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_x_i,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] x_q, y_q, o_q;
  logic [SUM_W-1:0]  sum;

  assign sum = {1'b0, x_q} + {1'b0, y_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
      o_q <= '0;
    end else begin
      if (cap_x_i) x_q <= in_data_i;
      if (commit_i) begin
        o_q <= sum[SUM_W-1:1];
        y_q <= x_q;
      end
    end
  end

  assign out_data_o = o_q;
endmodule

// File: rtl/avg2_filter.sv
module avg2_filter #(
  parameter int DATA_W  = 8,
  parameter int ADD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_req_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ack_o,
  output logic              out_req_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ack_i
);
  logic cap_x, commit;

  avg2_ctrl #(.ADD_LAT(ADD_LAT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_req_i (in_req_i),
    .out_ack_i(out_ack_i),
    .in_ack_o (in_ack_o),
    .out_req_o(out_req_o),
    .cap_x_o  (cap_x),
    .commit_o (commit)
  );

  avg2_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_x_i   (cap_x),
    .commit_i  (commit),
    .in_data_i (in_data_i),
    .out_data_o(out_data_o)
  );
endmodule

// File: rtl/avg2_filter_chk.sv
module avg2_filter_chk #(
  parameter int DATA_W  = 8,
  parameter int ADD_LAT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_req_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_ack_o,
  input logic              out_req_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ack_i
);
  logic        prev_ack_q;
  logic [15:0] lat_q;

  // cycles since in_ack_o fell, frozen once out_req_o is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ack_q <= 1'b0;
      lat_q      <= '0;
    end else begin
      prev_ack_q <= in_ack_o;
      if (prev_ack_q && !in_ack_o)        lat_q <= 16'd1;
      else if (lat_q != 0 && !out_req_o) lat_q <= lat_q + 16'd1;
    end
  end

  a_r5_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o && in_req_i |=> in_ack_o);
  a_r5_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o && !in_req_i |=> !in_ack_o);
  a_r5_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> $past(in_req_i) && !out_req_o);
  a_r9_wait_out_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> !$past(out_ack_i));
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_req_o) |-> lat_q == 16'(ADD_LAT));
  a_r8_hold_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_req_o && !out_ack_i |=> out_req_o && $stable(out_data_o));
  a_r8_release_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_req_o && out_ack_i |=> !out_req_o);
  a_r8_one_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ack_o && out_req_o));

  logic unused_in;
  assign unused_in = ^in_data_i;
endmodule

bind avg2_filter avg2_filter_chk #(.DATA_W(DATA_W), .ADD_LAT(ADD_LAT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_req_i(in_req_i), .in_data_i(in_data_i),
  .in_ack_o(in_ack_o), .out_req_o(out_req_o), .out_data_o(out_data_o),
  .out_ack_i(out_ack_i)
);

// File: tb/avg2_filter_bench.sv
module avg2_filter_bench;
  localparam int DATA_W  = 8;
  localparam int ADD_LAT = 2;
  localparam int NV      = 8;
  // {input, expected}
  localparam logic [15:0] VEC [NV] = '{
    {8'd10,  8'd5},   {8'd20,  8'd15},  {8'd255, 8'd137}, {8'd255, 8'd255},
    {8'd0,   8'd127}, {8'd1,   8'd0},   {8'd3,   8'd2},   {8'd100, 8'd51}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_req = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_ack, out_req, out_ack = 1'b0;
  logic [DATA_W-1:0] out_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  avg2_filter #(.DATA_W(DATA_W), .ADD_LAT(ADD_LAT)) u_avg2_filter (
    .clk_i(clk), .rst_ni(rst_n), .in_req_i(in_req), .in_data_i(in_data),
    .in_ack_o(in_ack), .out_req_o(out_req), .out_data_o(out_data),
    .out_ack_i(out_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one full transfer; keep_ack leaves out_ack high at the end
  task automatic xfer(input logic [7:0] x, input logic [7:0] exp, input string tag,
                      input bit keep_ack);
    int n = 0;
    @(negedge clk);
    in_data = x; in_req = 1'b1;
    while (!in_ack) @(negedge clk);
    in_data = ~x; in_req = 1'b0;   // R6: change data after capture
    @(negedge clk);
    chk(!in_ack, "R5 ack release", in_ack, 0);
    while (!out_req) begin @(negedge clk); n++; end
    chk(n == ADD_LAT, "R7 latency", n, ADD_LAT);
    chk(out_data == exp, {tag, " result"}, out_data, exp);
    repeat (3) @(negedge clk);
    chk(out_req && out_data == exp, "R8 hold", out_data, exp);
    out_ack = 1'b1;
    @(negedge clk);
    chk(!out_req, "R8 req drop", out_req, 0);
    if (!keep_ack) out_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ack && !out_req, "R1 reset handshake", {in_ack, out_req}, 0);
    chk(out_data == 0, "R1 reset data", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ack, "R5 no ack without req", in_ack, 0);

    for (int i = 0; i < NV; i++)
      xfer(VEC[i][15:8], VEC[i][7:0], (i == 0) ? "R2" : (i == 3) ? "R3" : "R4", 1'b0);

    // R9: out_ack still high blocks the next acknowledge
    xfer(8'd7, 8'd53, "R4", 1'b1);
    in_data = 8'd9; in_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(!in_ack, "R9 blocked", in_ack, 0);
    out_ack = 1'b0;
    @(negedge clk);
    chk(in_ack, "R9 resumes", in_ack, 1);
    in_req = 1'b0;
    while (!out_req) @(negedge clk);
    chk(out_data == 8'd8, "R9 result", out_data, 8);
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;

    // R1: reset mid-stream clears previous sample
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    xfer(8'd40, 8'd20, "R1 cleared", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule